// File: doc/BRIEF.md
# Sticky Event Status and Interrupt Controller

This block gathers single-cycle event pulses from the surrounding chip into a status register of sticky flags. It keeps a second register that mirrors a set of live sense inputs, and it drives an interrupt line that behaves like an open-drain pin. Each sticky flag has its own mask bit. A read of the main status register returns the flags, clears them and releases the interrupt. Any change in the value of the live sense register raises a dedicated change flag, so software learns that the sense picture has moved without polling it.

The block also holds a two-byte signed measurement. While the hold bit is clear, new samples from a measurement stream overwrite both bytes together. Setting the hold bit freezes the value so that software can read the high and low bytes separately without mixing two samples. Sense mirroring and measurement capture are mutually exclusive: when measurement is enabled, the sense register reads as zero.

Register access uses simple read and write strobes with a byte-wide data path. Read data is registered and appears in the cycle after the read strobe.

Top module: `evt_status_ctrl`

## Requirements
- R1: After reset all registers read 0x00, and the interrupt is released (irq_oe_o=0, irq_n_o=1).
- R2: A pulse on evt_i[k] sets status bit k at address 0x00 (bit0 clip, bit1 slew complete, bit2 clock unlock). The bit stays set until 0x00 is read.
- R3: A read strobe to 0x00 returns the flags on rdata_o in the next cycle and clears every flag at the same edge.
- R4: An event that arrives in the same cycle as a read of 0x00 is not included in that read's data. It remains set afterwards.
- R5: Address 0x01 bits [2:0] show sense_i one cycle late while control bit1 (measure enable) is 0. They read 0 while control bit1 is 1.
- R6: Any change in the value of address 0x01 sets status bit3 (sense change).
- R7: The interrupt asserts (irq_oe_o=1, irq_n_o=0) the cycle after a status flag is set whose enable bit, in the same position at address 0x04, is 1. Masked flags never assert it.
- R8: Once asserted, the interrupt stays asserted until 0x00 is read, regardless of further events or mask writes. It releases in the cycle after that read, unless an enabled flag is set in the read cycle.
- R9: Address 0x02 returns bits [15:8] and address 0x03 returns bits [7:0] of the last accepted sample. A sample is accepted when meas_vld_i=1, control bit1=1 and control bit0 (hold) =0.
- R10: While control bit0 is 1, both measurement bytes keep their value.
- R11: Writes to 0x00–0x03 are ignored. Address 0x04 stores bits [3:0] and address 0x05 stores bits [1:0]; unused bits read 0. Other addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | 3 | Event pulses: clip, slew complete, clock unlock |
| sense_i | input | 3 | Live sense bits: line-output, jack, microphone |
| meas_i | input | 16 | Signed measurement sample |
| meas_vld_i | input | 1 | Sample strobe for meas_i |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_n_o | output | 1 | Interrupt level, active low |
| irq_oe_o | output | 1 | Interrupt drive enable (pull low when 1) |

## Verification
The hardest case to reach from the ports is an event pulse, or a sense edge, that lands in the very cycle in which 0x00 is read. In that cycle the clear and the set race each other, and the interrupt must come straight back if the flag is enabled. Directed sequences place an event on the read strobe cycle, with and without its mask bit set. The random phase then fires sparse events, sense toggles and reads in the same cycles many times, and checks each cycle against a bench model.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
  // Register offsets (status clear-on-read at offset zero)
  localparam int A_STATUS = 0;
  localparam int A_SENSE  = 1;
  localparam int A_MEAS_H = 2;
  localparam int A_MEAS_L = 3;
  localparam int A_IEN    = 4;
  localparam int A_CTRL   = 5;

  // Control register bit positions
  localparam int C_HOLD   = 0;
  localparam int C_MEASEN = 1;
  localparam int C_BITS   = 2;
endpackage

// File: rtl/esc_sticky_flags.sv
module esc_sticky_flags #(
  parameter int N_FLAG = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_FLAG-1:0] set_i,
  input  logic              clr_i,
  input  logic [N_FLAG-1:0] ien_i,
  output logic [N_FLAG-1:0] flags_o,
  output logic              irq_o
);
  logic [N_FLAG-1:0] flags_q, flags_nxt;
  logic              irq_q, irq_nxt;

  // New flags win over the clear so no event is dropped.
  function automatic logic [N_FLAG-1:0] next_flags(
    input logic [N_FLAG-1:0] cur, input logic clr, input logic [N_FLAG-1:0] set);
    next_flags = (clr ? '0 : cur) | set;
  endfunction

  // Interrupt is sticky: only a status read can drop it.
  function automatic logic next_irq(
    input logic cur, input logic clr, input logic [N_FLAG-1:0] fl,
    input logic [N_FLAG-1:0] en);
    next_irq = (cur & ~clr) | (|(fl & en));
  endfunction

  always_comb begin
    flags_nxt = next_flags(flags_q, clr_i, set_i);
    irq_nxt   = next_irq(irq_q, clr_i, flags_nxt, ien_i);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_nxt;
      irq_q   <= irq_nxt;
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/esc_sense_track.sv
module esc_sense_track #(
  parameter int N_SENSE = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SENSE-1:0] sense_i,
  input  logic               det_en_i,
  output logic [N_SENSE-1:0] sense_o,
  output logic               chg_o
);
  logic [N_SENSE-1:0] sense_q, sense_nxt;

  always_comb begin
    sense_nxt = det_en_i ? sense_i : '0;
    chg_o     = (sense_nxt != sense_q);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) sense_q <= '0;
    else         sense_q <= sense_nxt;
  end

  assign sense_o = sense_q;
endmodule

// File: rtl/esc_meas_hold.sv
module esc_meas_hold #(
  parameter int MEAS_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MEAS_W-1:0] sample_i,
  input  logic              vld_i,
  input  logic              en_i,
  input  logic              hold_i,
  output logic [MEAS_W-1:0] meas_o,
  output logic              take_o
);
  logic [MEAS_W-1:0] meas_q;

  // All bytes load on one edge, so a split read never mixes samples.
  assign take_o = vld_i & en_i & ~hold_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     meas_q <= '0;
    else if (take_o) meas_q <= sample_i;
  end

  assign meas_o = meas_q;
endmodule

// File: rtl/evt_status_ctrl.sv
module evt_status_ctrl
  import evt_status_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int N_EVT   = 3,
  parameter int N_SENSE = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_EVT-1:0]    evt_i,
  input  logic [N_SENSE-1:0]  sense_i,
  input  logic [2*DATA_W-1:0] meas_i,
  input  logic                meas_vld_i,
  input  logic                rd_en_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_n_o,
  output logic                irq_oe_o
);
  localparam int MEAS_W = 2 * DATA_W;
  localparam int N_FLAG = N_EVT + 1;
  localparam logic [DATA_W-1:0] IEN_MASK  = DATA_W'((1 << N_FLAG) - 1);
  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << C_BITS) - 1);

  logic [DATA_W-1:0]  ien_q, ctrl_q, rdata_q, rd_mux;
  logic [N_FLAG-1:0]  flags_q, flag_set;
  logic [N_SENSE-1:0] sense_q;
  logic [MEAS_W-1:0]  meas_q;
  logic               sense_chg, meas_take, irq_q;
  logic               rd_status, wr_ien, wr_ctrl;
  logic               cap_q, meas_en_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    hit = (a == ADDR_W'(off));
  endfunction

  function automatic logic [DATA_W-1:0] meas_byte(
    input logic [MEAS_W-1:0] m, input logic upper);
    meas_byte = upper ? m[MEAS_W-1:DATA_W] : m[DATA_W-1:0];
  endfunction

  assign rd_status = rd_en_i & hit(addr_i, A_STATUS);
  assign wr_ien    = wr_en_i & hit(addr_i, A_IEN);
  assign wr_ctrl   = wr_en_i & hit(addr_i, A_CTRL);
  assign cap_q     = ctrl_q[C_HOLD];
  assign meas_en_q = ctrl_q[C_MEASEN];
  assign flag_set  = {sense_chg, evt_i};

  esc_sense_track #(.N_SENSE(N_SENSE)) u_sense (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sense_i  (sense_i),
    .det_en_i (~meas_en_q),
    .sense_o  (sense_q),
    .chg_o    (sense_chg)
  );

  esc_sticky_flags #(.N_FLAG(N_FLAG)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set),
    .clr_i   (rd_status),
    .ien_i   (ien_q[N_FLAG-1:0]),
    .flags_o (flags_q),
    .irq_o   (irq_q)
  );

  esc_meas_hold #(.MEAS_W(MEAS_W)) u_meas (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (meas_i),
    .vld_i    (meas_vld_i),
    .en_i     (meas_en_q),
    .hold_i   (cap_q),
    .meas_o   (meas_q),
    .take_o   (meas_take)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ien_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_ien)  ien_q  <= wdata_i & IEN_MASK;
      if (wr_ctrl) ctrl_q <= wdata_i & CTRL_MASK;
    end
  end

  always_comb begin
    rd_mux = '0;
    if      (hit(addr_i, A_STATUS)) rd_mux = DATA_W'(flags_q);
    else if (hit(addr_i, A_SENSE))  rd_mux = DATA_W'(sense_q);
    else if (hit(addr_i, A_MEAS_H)) rd_mux = meas_byte(meas_q, 1'b1);
    else if (hit(addr_i, A_MEAS_L)) rd_mux = meas_byte(meas_q, 1'b0);
    else if (hit(addr_i, A_IEN))    rd_mux = ien_q & IEN_MASK;
    else if (hit(addr_i, A_CTRL))   rd_mux = ctrl_q & CTRL_MASK;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o  = rdata_q;
  assign irq_oe_o = irq_q;
  assign irq_n_o  = ~irq_q;
endmodule

// File: rtl/esc_checker.sv
module esc_checker #(
  parameter int N_EVT   = 3,
  parameter int N_SENSE = 3,
  parameter int DATA_W  = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_status,
  input logic [N_EVT-1:0]    evt,
  input logic [N_EVT:0]      flags,
  input logic [N_EVT:0]      flag_set,
  input logic [DATA_W-1:0]   ien,
  input logic                irq_oe,
  input logic                irq_n,
  input logic                cap,
  input logic                meas_en,
  input logic [N_SENSE-1:0]  sense,
  input logic [2*DATA_W-1:0] meas
);
  // R3
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && (flag_set == '0) |=> (flags == '0));

  // R4
  event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && evt[0] |=> flags[0]);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe && !rd_status |=> irq_oe);

  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_oe && !rd_status && (|(flags & ien[N_EVT:0])) |=> irq_oe);

  // R7
  irq_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe != irq_n);

  // R10
  meas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> $stable(meas));

  // R5
  sense_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_en |=> (sense == '0));

  // R6
  sense_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense != $past(sense)) |-> flags[N_EVT]);
endmodule

bind evt_status_ctrl esc_checker #(
  .N_EVT(N_EVT), .N_SENSE(N_SENSE), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .rd_status (rd_status),
  .evt       (evt_i),
  .flags     (flags_q),
  .flag_set  (flag_set),
  .ien       (ien_q),
  .irq_oe    (irq_oe_o),
  .irq_n     (irq_n_o),
  .cap       (cap_q),
  .meas_en   (meas_en_q),
  .sense     (sense_q),
  .meas      (meas_q)
);

// File: tb/sim_evt_status_ctrl.sv
module sim_evt_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  evt = '0;
  logic [2:0]  sense = '0;
  logic [15:0] meas = '0;
  logic        mvld = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq_n, irq_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model state
  logic [3:0]  m_flags = '0, m_ien = '0;
  logic [1:0]  m_ctrl = '0;
  logic [2:0]  m_sense = '0;
  logic [15:0] m_meas = '0;
  logic        m_irq = 1'b0;

  always #2.5 clk = ~clk;

  evt_status_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .sense_i(sense),
    .meas_i(meas), .meas_vld_i(mvld), .rd_en_i(rd), .wr_en_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_n_o(irq_n), .irq_oe_o(irq_oe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [3:0] a);
    case (a)
      4'd0: model_read = {4'b0, m_flags};
      4'd1: model_read = {5'b0, m_sense};
      4'd2: model_read = m_meas[15:8];
      4'd3: model_read = m_meas[7:0];
      4'd4: model_read = {4'b0, m_ien};
      4'd5: model_read = {6'b0, m_ctrl};
      default: model_read = 8'h00;
    endcase
  endfunction

  function automatic string addr_req(input logic [3:0] a);
    case (a)
      4'd0: addr_req = "R3";
      4'd1: addr_req = "R5";
      4'd2, 4'd3: addr_req = "R9";
      default: addr_req = "R11";
    endcase
  endfunction

  // One bus cycle: drive at negedge, check just after posedge.
  task automatic cyc(input logic [2:0] e, input logic [2:0] s, input logic v,
                     input logic [15:0] md, input logic r, input logic w,
                     input logic [3:0] a, input logic [7:0] wd, input string tag);
    logic [7:0] exp_rd;
    logic [2:0] s_new;
    logic       rd0;
    evt = e; sense = s; mvld = v; meas = md; rd = r; wr = w; addr = a; wdata = wd;
    exp_rd = model_read(a);
    rd0    = r && (a == 4'd0);
    s_new  = m_ctrl[1] ? 3'b000 : s;
    m_flags = (rd0 ? 4'b0 : m_flags) | {(s_new != m_sense), e};
    m_irq   = (m_irq && !rd0) || (|(m_flags & m_ien));
    if (v && m_ctrl[1] && !m_ctrl[0]) m_meas = md;
    m_sense = s_new;
    if (w && a == 4'd4) m_ien  = wd[3:0];
    if (w && a == 4'd5) m_ctrl = wd[1:0];
    @(posedge clk); #1;
    check("R8", {15'b0, irq_oe}, {15'b0, m_irq});
    check("R7", {15'b0, irq_n}, {15'b0, !m_irq});
    if (r) check(tag != "" ? tag : addr_req(a), {8'b0, rdata}, {8'b0, exp_rd});
    @(negedge clk);
    evt = '0; mvld = 1'b0; rd = 1'b0; wr = 1'b0;
  endtask

  task automatic rdreg(input logic [3:0] a, input string tag);
    cyc(3'b0, sense, 1'b0, 16'h0, 1'b1, 1'b0, a, 8'h0, tag);
  endtask

  task automatic wrreg(input logic [3:0] a, input logic [7:0] d);
    cyc(3'b0, sense, 1'b0, 16'h0, 1'b0, 1'b1, a, d, "");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", {15'b0, irq_oe}, 16'h0);
    check("R1", {15'b0, irq_n}, 16'h1);
    for (int a = 0; a < 6; a++) rdreg(4'(a), "R1");

    // R11: writes to read-only offsets ignored, masks on writable ones
    wrreg(4'd0, 8'hFF); wrreg(4'd2, 8'hFF); wrreg(4'd3, 8'hFF);
    rdreg(4'd0, "R11"); rdreg(4'd2, "R11"); rdreg(4'd3, "R11");
    wrreg(4'd4, 8'hF0); rdreg(4'd4, "R11");
    wrreg(4'd5, 8'hFC); rdreg(4'd5, "R11");
    wrreg(4'd9, 8'h55); rdreg(4'd9, "R11");

    // R2: each event sets its own bit, masked so no interrupt (R7)
    cyc(3'b001, 3'b0, 0, 0, 0, 0, 0, 0, "");
    cyc(3'b100, 3'b0, 0, 0, 0, 0, 0, 0, "");
    rdreg(4'd0, "R2");
    cyc(3'b010, 3'b0, 0, 0, 0, 0, 0, 0, "");
    rdreg(4'd0, "R2");

    // R4: event in the read cycle survives the clear
    cyc(3'b001, 3'b0, 0, 0, 0, 0, 0, 0, "");
    cyc(3'b100, 3'b0, 0, 0, 1, 0, 4'd0, 0, "R4");
    rdreg(4'd0, "R4");

    // R8: enabled clip event, repeat events, mask removal keep it asserted
    wrreg(4'd4, 8'h01);
    cyc(3'b001, 3'b0, 0, 0, 0, 0, 0, 0, "");
    cyc(3'b011, 3'b0, 0, 0, 0, 0, 0, 0, "");
    wrreg(4'd4, 8'h00);
    check("R8", {15'b0, irq_oe}, 16'h1);
    rdreg(4'd0, "R8");
    check("R8", {15'b0, irq_oe}, 16'h0);
    // enabled event in the read cycle brings the interrupt back
    wrreg(4'd4, 8'h04);
    cyc(3'b100, 3'b0, 0, 0, 0, 0, 0, 0, "");
    cyc(3'b100, 3'b0, 0, 0, 1, 0, 4'd0, 0, "R8");
    check("R8", {15'b0, irq_oe}, 16'h1);
    rdreg(4'd0, "R8");

    // R5 and R6: sense mirroring and change flag
    wrreg(4'd4, 8'h08);
    cyc(3'b0, 3'b101, 0, 0, 0, 0, 0, 0, "");
    rdreg(4'd1, "R5");
    rdreg(4'd0, "R6");
    wrreg(4'd5, 8'h02);
    rdreg(4'd1, "R5");
    rdreg(4'd0, "R6");

    // R9 and R10: sample acceptance and hold
    cyc(3'b0, sense, 1, 16'hA5C3, 0, 0, 0, 0, "");
    rdreg(4'd2, "R9"); rdreg(4'd3, "R9");
    wrreg(4'd5, 8'h03);
    cyc(3'b0, sense, 1, 16'h1234, 0, 0, 0, 0, "");
    rdreg(4'd2, "R10");
    cyc(3'b0, sense, 1, 16'h5678, 0, 0, 0, 0, "");
    rdreg(4'd3, "R10");
    wrreg(4'd5, 8'h00);
    cyc(3'b0, sense, 1, 16'h9ABC, 0, 0, 0, 0, "");
    rdreg(4'd3, "R9");
    rdreg(4'd0, "");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] e, s;
      logic r, w, v;
      logic [3:0] a;
      logic [7:0] wd;
      e  = ($urandom % 8 == 0) ? 3'($urandom) : 3'b0;
      s  = ($urandom % 10 == 0) ? 3'($urandom) : sense;
      v  = ($urandom % 3 == 0);
      r  = ($urandom % 4 == 0);
      w  = !r && ($urandom % 16 == 0);
      a  = w ? (($urandom % 2 == 0) ? 4'd4 : 4'd5)
             : (($urandom % 2 == 0) ? 4'd0 : 4'($urandom % 8));
      wd = 8'($urandom);
      cyc(e, s, v, 16'($urandom), r, w, a, wd, "");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule